// File: doc/BRIEF.md
# Remote DMA Data Port

This block is the host-side data window into a network controller's packet memory. A host access goes to the current remote address and moves one, two or four bytes. A byte or word access moves one or two bytes, chosen by a configuration bit. A long access always moves four bytes. After each access the current address moves forward and a remaining-byte count goes down by the size of the access. When the count is used up, the block pulses a completion flag that the interrupt logic outside latches. The register file outside loads the address and the count through load strobes. The ring start and stop pages come from that register file as plain levels.

Host requests arrive on a valid/ready channel. Read data leaves on a valid/ready response channel one cycle after a read is accepted. The block holds a single response register. While that response is offered and not taken, `req_ready` stays low. `req_ready` also stays low in any cycle in which the address or the count is being loaded. Writes produce no response. Port offset 0x1F is a separate reset port. A read there rebuilds the 32-byte identification area at the bottom of memory from the station address and returns zero.

Only two areas are backed: the 32-byte identification area, and a packet window that starts at `WIN_BASE` and is `WIN_BYTES` long. The full-size window is 16 KB to 48 KB. A smaller default keeps elaboration light.

Top module: `rdma_port`

## Requirements
- R1: The access size in bytes is 4 when `req_long` is set. Otherwise it is 2 when `cfg_word_mode` is 1 and 1 when `cfg_word_mode` is 0. A performed access advances `cur_addr` by that size, modulo 2^16.
- R2: Word and long accesses use the current address with bit 0 cleared. Byte k of the access sits at that address plus k and maps to `rsp_data`/`req_wdata` bits 8k+7..8k (little-endian). Response lanes above the access size read as zero.
- R3: Only byte addresses below 32, or from `WIN_BASE` up to but not including `WIN_BASE+WIN_BYTES`, are backed. A read lane outside them returns 0xFF, and a write lane outside them leaves memory unchanged.
- R4: If the advanced address equals `{ring_stop_pg,8'h00}`, `cur_addr` is instead loaded with `{ring_start_pg,8'h00}`.
- R5: If the remaining count is less than or equal to the access size, `cur_count` becomes 0 and `dma_done_set` is high for the one cycle after the access. Otherwise `cur_count` drops by the access size and `dma_done_set` stays low.
- R6: A write accepted while `cur_count` is 0 changes nothing: not memory, not the address, and not the completion flag. A read at count 0 is still performed, advances the address and pulses `dma_done_set`.
- R7: Port 0x1F is the reset port; any other port offset is the data port. A read at 0x1F returns 0, leaves the address and count alone, and rewrites bytes 0..31. Bytes 2i and 2i+1 for i<6 both get station byte i, where byte 0 is `station_addr[7:0]`. Bytes 12..27 get 0x00. Bytes 28..31 get 0x57. A write at 0x1F has no effect.
- R8: Read data appears with `rsp_valid` in the cycle after acceptance. While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` holds, `rsp_valid` stays high and `req_ready` is low.
- R9: `addr_load`/`cnt_load` set `cur_addr`/`cur_count` to the supplied value on the next edge. `req_ready` is low in any cycle in which either load is high.
- R10: After reset `cur_addr` and `cur_count` are 0, `rsp_valid` and `dma_done_set` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word_mode | input | 1 | 1: non-long accesses move 2 bytes; 0: 1 byte |
| ring_start_pg | input | 8 | Ring start page (address bits 15:8) |
| ring_stop_pg | input | 8 | Ring stop page, one past the last ring page |
| station_addr | input | 48 | Station address used by the reset-port reload |
| addr_load | input | 1 | Load strobe for the current address |
| addr_load_val | input | 16 | Value for the current address |
| cnt_load | input | 1 | Load strobe for the remaining count |
| cnt_load_val | input | 16 | Value for the remaining count |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request accepted when high with valid |
| req_write | input | 1 | 1 write, 0 read |
| req_long | input | 1 | 4-byte access |
| req_port | input | 5 | Port offset; 0x1F is the reset port |
| req_wdata | input | 32 | Write data, little-endian lanes |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response taken when high with valid |
| rsp_data | output | 32 | Read response data |
| cur_addr | output | 16 | Current remote address |
| cur_count | output | 16 | Remaining byte count |
| dma_done_set | output | 1 | One-cycle pulse: count exhausted |

## Verification
Two outcomes can fall on the same access: the ring wrap at the stop page and the count running out. The bench places a word write two bytes below the stop page with a count of exactly two. It then checks that the address reloads to the start page and that `dma_done_set` pulses with the count at zero, both in the cycle after acceptance. A second pairing is a response stall against a new request. The bench holds `rsp_ready` low and judges that `req_ready` drops while the response data stays put until it is taken.

// File: rtl/rdma_pkg.sv
`timescale 1ns/1ps
package rdma_pkg;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_WORD = 2'd1,
    ACC_LONG = 2'd2
  } acc_kind_e;

  localparam logic [4:0] PORT_RESET = 5'h1F;
  localparam int         PROM_BYTES = 32;
  localparam logic [7:0] PROM_MARK  = 8'h57;
  localparam int         LANES      = 4;

  function automatic logic [2:0] step_of(acc_kind_e k);
    case (k)
      ACC_LONG: return 3'd4;
      ACC_WORD: return 3'd2;
      default:  return 3'd1;
    endcase
  endfunction

  // Byte idx of the identification area after a reload.
  function automatic logic [7:0] prom_seed(int idx, logic [47:0] sa);
    int src;
    src = idx / 2;
    if (src < 6)        return sa[8*src +: 8];
    else if (src >= 14) return PROM_MARK;
    else                return 8'h00;
  endfunction

endpackage

// File: rtl/rdma_addr_ctrl.sv
`timescale 1ns/1ps
module rdma_addr_ctrl #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-9:0] start_pg,
  input  logic [ADDR_W-9:0] stop_pg,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_load_val,
  input  logic              cnt_load,
  input  logic [CNT_W-1:0]  cnt_load_val,
  input  logic              acc_fire,
  input  logic              acc_write,
  input  logic [2:0]        acc_step,
  output logic              acc_live,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              done_q
);

  logic [ADDR_W-1:0] ring_start, ring_stop, next_addr, wrap_addr;
  logic              exhaust, advance;

  assign ring_start = {start_pg, 8'h00};
  assign ring_stop  = {stop_pg, 8'h00};
  assign eff_addr   = (acc_step > 3'd1) ? {addr_q[ADDR_W-1:1], 1'b0} : addr_q;
  assign next_addr  = addr_q + ADDR_W'(acc_step);
  assign wrap_addr  = (next_addr == ring_stop) ? ring_start : next_addr;
  assign exhaust    = cnt_q <= CNT_W'(acc_step);
  assign acc_live   = !(acc_write && (cnt_q == '0));
  assign advance    = acc_fire && acc_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (addr_load)    addr_q <= addr_load_val;
      else if (advance) addr_q <= wrap_addr;
      if (cnt_load)     cnt_q  <= cnt_load_val;
      else if (advance) cnt_q  <= exhaust ? '0 : cnt_q - CNT_W'(acc_step);
      if (advance && exhaust && !cnt_load) done_q <= 1'b1;
    end
  end

  assert_done_means_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (cnt_q == '0));

  assert_count_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !exhaust && !cnt_load) |=> (cnt_q == $past(cnt_q) - CNT_W'($past(acc_step))));

  assert_never_parks_on_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !addr_load && (start_pg != stop_pg)) |=> (addr_q != {$past(stop_pg), 8'h00}));

  assert_zero_count_write_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && acc_write && (cnt_q == '0) && !addr_load && !cnt_load)
      |=> ($stable(addr_q) && !done_q));

endmodule

// File: rtl/rdma_byte_store.sv
`timescale 1ns/1ps
module rdma_byte_store
  import rdma_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int WIN_BASE  = 'h4000,
  parameter int WIN_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic              reload,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [2:0]        nbytes,
  input  logic [31:0]       wdata,
  input  logic [47:0]       station,
  output logic [31:0]       rdata
);

  localparam int ROWS    = WIN_BYTES / LANES;
  localparam int ROW_W   = $clog2(ROWS);
  localparam int LA_W    = ADDR_W + 1;
  localparam int WIN_END = WIN_BASE + WIN_BYTES;

  // Per-lane byte address, one bit wider so a carry never aliases low memory.
  logic [LA_W-1:0]  lane_addr [LANES];
  logic [LANES-1:0] lane_on, lane_prom, lane_win;

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      lane_addr[k] = {1'b0, base_addr} + LA_W'(k);
      lane_on[k]   = 3'(k) < nbytes;
      lane_prom[k] = lane_addr[k] < LA_W'(PROM_BYTES);
      lane_win[k]  = (lane_addr[k] >= LA_W'(WIN_BASE)) && (lane_addr[k] < LA_W'(WIN_END));
    end
  end

  // Window storage: four byte banks, bank j holds addresses with (a mod 4) == j.
  logic [7:0] bank_rd [LANES];

  for (genvar j = 0; j < LANES; j++) begin : g_bank
    logic [1:0]       lane_sel;
    logic [LA_W-1:0]  win_off;
    logic [ROW_W-1:0] row;
    logic             bank_we;
    logic [7:0]       wbyte;
    logic [7:0]       q_r;
    logic [7:0]       mem [ROWS];
    logic             unused_off;

    assign lane_sel   = 2'(j) - base_addr[1:0];
    assign win_off    = lane_addr[lane_sel] - LA_W'(WIN_BASE);
    assign row        = win_off[ROW_W+1:2];
    assign bank_we    = wr_en && lane_on[lane_sel] && lane_win[lane_sel];
    assign wbyte      = wdata[8*lane_sel +: 8];
    assign unused_off = ^{win_off[LA_W-1:ROW_W+2], win_off[1:0]};

    always_ff @(posedge clk) begin
      if (bank_we) mem[row] <= wbyte;
      if (rd_en)   q_r      <= mem[row];
    end

    assign bank_rd[j] = q_r;
  end

  // Identification area: 32 flops, rebuilt in one cycle by a reload.
  logic [7:0]       prom [PROM_BYTES];
  logic [7:0]       prom_rd_q [LANES];
  logic [1:0]       off_q;
  logic [LANES-1:0] on_q, win_q, prom_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PROM_BYTES; i++) prom[i] <= 8'h00;
    end else if (reload) begin
      for (int i = 0; i < PROM_BYTES; i++) prom[i] <= prom_seed(i, station);
    end else if (wr_en) begin
      for (int k = 0; k < LANES; k++)
        if (lane_on[k] && lane_prom[k]) prom[lane_addr[k][4:0]] <= wdata[8*k +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q  <= '0;
      on_q   <= '0;
      win_q  <= '0;
      prom_q <= '0;
      for (int k = 0; k < LANES; k++) prom_rd_q[k] <= 8'h00;
    end else if (rd_en) begin
      off_q  <= base_addr[1:0];
      on_q   <= lane_on;
      win_q  <= lane_win;
      prom_q <= lane_prom;
      for (int k = 0; k < LANES; k++) prom_rd_q[k] <= prom[lane_addr[k][4:0]];
    end
  end

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      if (!on_q[k])       rdata[8*k +: 8] = 8'h00;
      else if (win_q[k])  rdata[8*k +: 8] = bank_rd[2'(k) + off_q];
      else if (prom_q[k]) rdata[8*k +: 8] = prom_rd_q[k];
      else                rdata[8*k +: 8] = 8'hFF;
    end
  end

  assert_reload_layout_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> ((prom[PROM_BYTES-1] == PROM_MARK) && (prom[1] == $past(station[7:0]))
                && (prom[20] == 8'h00)));

endmodule

// File: rtl/rdma_port.sv
`timescale 1ns/1ps
module rdma_port
  import rdma_pkg::*;
#(
  parameter int WIN_BASE  = 'h4000,
  parameter int WIN_BYTES = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_word_mode,
  input  logic [7:0]  ring_start_pg,
  input  logic [7:0]  ring_stop_pg,
  input  logic [47:0] station_addr,
  input  logic        addr_load,
  input  logic [15:0] addr_load_val,
  input  logic        cnt_load,
  input  logic [15:0] cnt_load_val,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic        req_long,
  input  logic [4:0]  req_port,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_data,
  output logic [15:0] cur_addr,
  output logic [15:0] cur_count,
  output logic        dma_done_set
);

  localparam int ADDR_W = 16;
  localparam int CNT_W  = 16;

  acc_kind_e         kind;
  logic [2:0]        step;
  logic              fire, at_reset_port, data_fire, live, reload, rd_en, wr_en;
  logic [ADDR_W-1:0] eff_addr;
  logic [31:0]       store_rd;
  logic              rsp_zero_q;

  assign kind          = req_long ? ACC_LONG : (cfg_word_mode ? ACC_WORD : ACC_BYTE);
  assign step          = step_of(kind);
  assign req_ready     = !(rsp_valid && !rsp_ready) && !addr_load && !cnt_load;
  assign fire          = req_valid && req_ready;
  assign at_reset_port = req_port == PORT_RESET;
  assign data_fire     = fire && !at_reset_port;
  assign reload        = fire && at_reset_port && !req_write;
  assign rd_en         = data_fire && !req_write;
  assign wr_en         = data_fire && req_write && live;

  rdma_addr_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_pg     (ring_start_pg),
    .stop_pg      (ring_stop_pg),
    .addr_load    (addr_load),
    .addr_load_val(addr_load_val),
    .cnt_load     (cnt_load),
    .cnt_load_val (cnt_load_val),
    .acc_fire     (data_fire),
    .acc_write    (req_write),
    .acc_step     (step),
    .acc_live     (live),
    .eff_addr     (eff_addr),
    .addr_q       (cur_addr),
    .cnt_q        (cur_count),
    .done_q       (dma_done_set)
  );

  rdma_byte_store #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .reload   (reload),
    .base_addr(eff_addr),
    .nbytes   (step),
    .wdata    (req_wdata),
    .station  (station_addr),
    .rdata    (store_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_zero_q <= 1'b0;
    end else if (fire && !req_write) begin
      rsp_valid  <= 1'b1;
      rsp_zero_q <= at_reset_port;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end

  assign rsp_data = rsp_zero_q ? 32'h0 : store_rd;

  assert_stall_holds_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  assert_read_answers_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);

  assert_load_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
    addr_load |=> (cur_addr == $past(addr_load_val)));

endmodule

// File: tb/rdma_port_bench.sv
`timescale 1ns/1ps
module rdma_port_bench;

  localparam int WB = 'h4000;
  localparam int WN = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_word_mode = 1'b0;
  logic [7:0]  ring_start_pg = 8'h40;
  logic [7:0]  ring_stop_pg = 8'h44;
  logic [47:0] station_addr = 48'h665544332211;
  logic        addr_load = 1'b0, cnt_load = 1'b0;
  logic [15:0] addr_load_val = '0, cnt_load_val = '0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_long = 1'b0;
  logic [4:0]  req_port = 5'h10;
  logic [31:0] req_wdata = '0;
  logic        rsp_ready = 1'b1;
  logic        req_ready, rsp_valid, dma_done_set;
  logic [31:0] rsp_data;
  logic [15:0] cur_addr, cur_count;

  always #2.5 clk = ~clk;

  rdma_port #(.WIN_BASE(WB), .WIN_BYTES(WN)) u_rdma_port (.*);

  int          n_vec = 0, n_bad = 0;
  logic [7:0]  mdl [int];
  logic [31:0] exp_q [$];
  int          m_addr = 0, m_cnt = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit backed(int a);
    return (a < 32) || (a >= WB && a < WB + WN);
  endfunction

  function automatic logic [7:0] rd_byte(int a);
    if (!backed(a)) return 8'hFF;
    return mdl.exists(a) ? mdl[a] : 8'h00;
  endfunction

  // Scoreboard monitor: every taken response is compared with the queue head.
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) check("R8 unexpected response", rsp_data, 32'hx);
      else check("R2 R3 R7 read data", rsp_data, exp_q.pop_front());
    end
  end

  task automatic load(input int a, input int c);
    @(negedge clk);
    addr_load = 1'b1; addr_load_val = 16'(a);
    cnt_load  = 1'b1; cnt_load_val  = 16'(c);
    #1 check("R9 ready low while loading", {31'b0, req_ready}, 32'd0);
    @(negedge clk);
    addr_load = 1'b0; cnt_load = 1'b0;
    m_addr = a; m_cnt = c;
    check("R9 address loaded", {16'b0, cur_addr}, 32'(a));
    check("R9 count loaded", {16'b0, cur_count}, 32'(c));
  endtask

  task automatic acc(input bit wr, input bit lg, input logic [4:0] port,
                     input logic [31:0] wd, input string req);
    int          step, eff;
    bit          exp_done;
    logic [31:0] exp;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_long = lg; req_port = port; req_wdata = wd;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    step = lg ? 4 : (cfg_word_mode ? 2 : 1);
    exp_done = 1'b0;
    if (port == 5'h1F) begin
      if (!wr) begin
        exp_q.push_back(32'h0);
        for (int i = 0; i < 32; i++)
          mdl[i] = (i/2 < 6) ? station_addr[8*(i/2) +: 8] : ((i >= 28) ? 8'h57 : 8'h00);
      end
    end else if (!(wr && m_cnt == 0)) begin
      eff = (step > 1) ? (m_addr & 'hFFFE) : m_addr;
      exp = '0;
      for (int k = 0; k < step; k++) begin
        if (wr) begin
          if (backed(eff + k)) mdl[eff + k] = wd[8*k +: 8];
        end else exp[8*k +: 8] = rd_byte(eff + k);
      end
      if (!wr) exp_q.push_back(exp);
      m_addr = (m_addr + step) & 'hFFFF;
      if (m_addr == {16'(ring_stop_pg), 8'h00}) m_addr = {16'(ring_start_pg), 8'h00};
      if (m_cnt <= step) begin m_cnt = 0; exp_done = 1'b1; end
      else m_cnt = m_cnt - step;
    end
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " address"}, {16'b0, cur_addr}, 32'(m_addr));
    check({req, " count"}, {16'b0, cur_count}, 32'(m_cnt));
    check({req, " done pulse"}, {31'b0, dma_done_set}, {31'b0, exp_done});
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset address", {16'b0, cur_addr}, 32'h0);
    check("R10 reset count", {16'b0, cur_count}, 32'h0);
    check("R10 reset rsp_valid", {31'b0, rsp_valid}, 32'h0);
    check("R10 reset done", {31'b0, dma_done_set}, 32'h0);
    check("R10 reset ready", {31'b0, req_ready}, 32'h1);

    // R1 R2: byte, word and long writes, then reads in every size.
    load('h4000, 16);
    cfg_word_mode = 1'b0;
    acc(1, 0, 5'h10, 32'hA1, "R1 byte write");
    acc(1, 0, 5'h10, 32'hB2, "R1 byte write");
    cfg_word_mode = 1'b1;
    acc(1, 0, 5'h10, 32'hD4C3, "R1 word write");
    acc(1, 1, 5'h10, 32'h88776655, "R1 long write");
    load('h4000, 16);
    acc(0, 1, 5'h10, 0, "R2 long read");
    cfg_word_mode = 1'b0;
    acc(0, 0, 5'h10, 0, "R1 byte read");
    cfg_word_mode = 1'b1;
    acc(0, 0, 5'h10, 0, "R2 odd word read");

    // R3: outside the backed areas.
    load('h3FFE, 8);
    acc(0, 0, 5'h10, 0, "R3 read below window");
    load('h8000, 8);
    acc(1, 0, 5'h10, 32'h1234, "R3 write outside");
    load('h8000, 8);
    acc(0, 0, 5'h10, 0, "R3 read outside");
    load('h43FE, 8);
    acc(1, 0, 5'h10, 32'h9ABC, "R4 write wraps at stop");
    load('h43FE, 8);
    acc(0, 1, 5'h10, 0, "R3 long read straddles window end");

    // R4 with R5 in the same access.
    ring_stop_pg = 8'h41;
    load('h40FE, 2);
    acc(1, 0, 5'h10, 32'h5566, "R4 R5 wrap and exhaust together");

    // R6: count zero.
    acc(1, 0, 5'h10, 32'hEEEE, "R6 write at zero ignored");
    acc(0, 0, 5'h10, 0, "R6 read at zero performed");

    // R5: partial steps.
    load('h4000, 3);
    acc(0, 0, 5'h10, 0, "R5 count above step");
    acc(0, 0, 5'h10, 0, "R5 count below step");

    // R7: reset port.
    acc(1, 0, 5'h1F, 32'hFFFF, "R7 write at reset port");
    acc(0, 0, 5'h1F, 0, "R7 reload read");
    load(0, 40);
    for (int i = 0; i < 8; i++) acc(0, 1, 5'h10, 0, "R7 identification bytes");
    cfg_word_mode = 1'b0;
    load(4, 4);
    acc(1, 0, 5'h10, 32'h3C, "R3 write low area");
    load(4, 4);
    acc(0, 0, 5'h10, 0, "R3 read low area");

    // R8: response stall.
    cfg_word_mode = 1'b1;
    load('h4000, 8);
    rsp_ready = 1'b0;
    acc(0, 0, 5'h10, 0, "R8 stalled read");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R8 ready low during stall", {31'b0, req_ready}, 32'h0);
      check("R8 valid held", {31'b0, rsp_valid}, 32'h1);
      check("R8 data held", rsp_data, 32'h0000B2A1);
    end
    rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 all responses seen", 32'(exp_q.size()), 32'h0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule